// File: doc/BRIEF.md
# ISA-Master Memory Cycle Claim Logic

This block sits in the target side of a host-to-PCI bridge. Its job is to spot PCI memory cycles that the PCI-to-ISA bridge places on the bus for an ISA bus master or for ISA DMA, and to claim them for system memory. The bridge has no sideband signal that reliably marks such a cycle. The block therefore infers one: when none of the four external PCI agents holds a grant during an address phase, the cycle must come from the ISA bridge. A flag built from the grant lines records that case.

When the flag is set, the block forwards the address to system memory unchanged, so it reaches the 0 to 2G range. Ordinary cycles from other agents reach system memory through the 2G to 4G window, and the block maps them by inverting the top address bit. The claim decision is made at the address clock from the command, the address, an own-initiator input and a populated-memory limit. It is never deferred to a late, subtractive decode. The decision, the flag and the mapped address are held until the bus returns to idle.

The control is a two-state machine. **ST_IDLE** waits for FRAME# to be sampled low. On that edge it latches the decode and takes the transition *addr_seen* to **ST_HELD**. ST_HELD ignores all bus inputs except FRAME# and IRDY#. When both are sampled high it takes the transition *bus_idle* back to ST_IDLE.

Top module: `isa_cycle_claim`

## Requirements
- R1: After reset the block is in ST_IDLE, and claim_o, ign_ad31_o and sys_addr_o are all 0.
- R2: The ignore flag is 1 only when all four active-low grant inputs are 1 at the clock where FRAME# is first sampled low. ign_ad31_o shows the latched flag while the block is in ST_HELD, and 0 in ST_IDLE.
- R3: Only memory commands can be claimed. These are C/BE# values 4'b0110, 4'b0111, 4'b1100, 4'b1110 and 4'b1111. Every other value, including I/O (4'b0010, 4'b0011), configuration (4'b1010, 4'b1011) and special cycle (4'b0001), is never claimed.
- R4: A cycle that this bridge initiated (self_init_i = 1 at the address clock) is never claimed.
- R5: With the flag set, sys_addr_o equals AD unchanged. The cycle is claimed when AD < mem_limit_i, whatever the value of AD[31].
- R6: With the flag clear, sys_addr_o equals AD with bit 31 inverted. The cycle is claimed only when AD[31] = 1 and the mapped address is below mem_limit_i.
- R7: The block stays in ST_HELD until FRAME# and IRDY# are both sampled high. On the clock after that, all three outputs read 0.
- R8: In ST_HELD, changes on AD, C/BE#, the grants, self_init_i or mem_limit_i have no effect on the outputs.
- R9: The claim decision appears on the first cycle after the address clock, with no later decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gnt_n_i | input | 4 | Active-low grants of the external PCI agents |
| frame_n_i | input | 1 | PCI FRAME#, active low |
| irdy_n_i | input | 1 | PCI IRDY#, active low |
| cbe_n_i | input | 4 | C/BE# command nibble during the address phase |
| ad_i | input | 32 | PCI address |
| self_init_i | input | 1 | 1 when this bridge is the initiator |
| mem_limit_i | input | 32 | First address above populated system memory |
| ign_ad31_o | output | 1 | Latched ISA-originated flag |
| claim_o | output | 1 | Claim (DEVSEL) request |
| sys_addr_o | output | 32 | Mapped system-memory address |

## Verification
The assertions check four things on every cycle:
- the flag rises only after all grants were high at the address clock;
- a new claim always follows a memory command, a foreign initiator and an address below the limit;
- the outputs stay stable while the block is held;
- the outputs clear after the bus goes idle.

Two things can only be shown by the bench scenarios, which compare against an independent model:
- that the right address mapping is chosen for each combination of flag and AD[31];
- that cycles which should be claimed are in fact claimed, including peer-to-peer addresses and the exact limit boundary.

// File: rtl/isa_claim_pkg.sv
package isa_claim_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } claim_state_e;

    // Memory read, write, read multiple, read line, write and invalidate
    function automatic logic is_mem_cmd(input logic [3:0] cmd_n);
        unique case (cmd_n)
            4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: is_mem_cmd = 1'b1;
            default:                                     is_mem_cmd = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/isa_grant_sense.sv
module isa_grant_sense #(
    parameter int NUM_AGENTS = 4
) (
    input  logic [NUM_AGENTS-1:0] gnt_n_i,
    output logic                  no_agent_o
);
    // Every external agent deasserted its grant: the ISA bridge owns the bus
    always_comb no_agent_o = &gnt_n_i;
endmodule

// File: rtl/isa_addr_map.sv
module isa_addr_map #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] ad_i,
    input  logic [3:0]    cbe_n_i,
    input  logic          isa_flag_i,
    input  logic          self_init_i,
    input  logic [AW-1:0] limit_i,
    output logic [AW-1:0] mapped_o,
    output logic          claim_o
);
    import isa_claim_pkg::*;

    localparam int          TOP  = AW - 1;
    localparam logic [AW-1:0] FLIP = {1'b1, {(AW-1){1'b0}}};

    logic window_hit;

    always_comb begin
        if (isa_flag_i) begin
            mapped_o   = ad_i;
            window_hit = 1'b1;
        end else begin
            mapped_o   = ad_i ^ FLIP;
            window_hit = ad_i[TOP];
        end
        claim_o = !self_init_i && is_mem_cmd(cbe_n_i) && window_hit
                  && (mapped_o < limit_i);
    end
endmodule

// File: rtl/isa_cycle_claim.sv
module isa_cycle_claim #(
    parameter int AW         = 32,
    parameter int NUM_AGENTS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_AGENTS-1:0] gnt_n_i,
    input  logic                  frame_n_i,
    input  logic                  irdy_n_i,
    input  logic [3:0]            cbe_n_i,
    input  logic [AW-1:0]         ad_i,
    input  logic                  self_init_i,
    input  logic [AW-1:0]         mem_limit_i,
    output logic                  ign_ad31_o,
    output logic                  claim_o,
    output logic [AW-1:0]         sys_addr_o
);
    import isa_claim_pkg::*;

    claim_state_e  state_q, state_d;
    logic          flag_now, claim_now;
    logic [AW-1:0] mapped_now;
    logic          flag_q, claim_q;
    logic [AW-1:0] addr_q;
    logic          addr_seen, bus_idle;

    isa_grant_sense #(.NUM_AGENTS(NUM_AGENTS)) u_sense (
        .gnt_n_i    (gnt_n_i),
        .no_agent_o (flag_now)
    );

    isa_addr_map #(.AW(AW)) u_map (
        .ad_i        (ad_i),
        .cbe_n_i     (cbe_n_i),
        .isa_flag_i  (flag_now),
        .self_init_i (self_init_i),
        .limit_i     (mem_limit_i),
        .mapped_o    (mapped_now),
        .claim_o     (claim_now)
    );

    always_comb begin
        addr_seen = !frame_n_i;
        bus_idle  = frame_n_i && irdy_n_i;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (addr_seen) state_d = ST_HELD;
            ST_HELD: if (bus_idle)  state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Decode capture at the address clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            claim_q <= 1'b0;
            addr_q  <= '0;
        end else if (state_q == ST_IDLE && addr_seen) begin
            flag_q  <= flag_now;
            claim_q <= claim_now;
            addr_q  <= mapped_now;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_HELD: begin
                ign_ad31_o = flag_q;
                claim_o    = claim_q;
                sys_addr_o = addr_q;
            end
            default: begin
                ign_ad31_o = 1'b0;
                claim_o    = 1'b0;
                sys_addr_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/isa_cycle_claim_chk.sv
module isa_cycle_claim_chk #(
    parameter int AW         = 32,
    parameter int NUM_AGENTS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_AGENTS-1:0] gnt_n_i,
    input logic                  frame_n_i,
    input logic                  irdy_n_i,
    input logic [3:0]            cbe_n_i,
    input logic [AW-1:0]         ad_i,
    input logic                  self_init_i,
    input logic [AW-1:0]         mem_limit_i,
    input logic                  ign_ad31_o,
    input logic                  claim_o,
    input logic [AW-1:0]         sys_addr_o,
    input isa_claim_pkg::claim_state_e state_q
);
    import isa_claim_pkg::*;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!claim_o && !ign_ad31_o && sys_addr_o == '0)); // R1

    AST_FLAG_FROM_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ign_ad31_o) |-> $past(&gnt_n_i)); // R2

    AST_CLAIM_MEM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(claim_o) |-> $past(is_mem_cmd(cbe_n_i))); // R3

    AST_CLAIM_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(claim_o) |-> $past(!self_init_i)); // R4

    AST_ISA_DIRECT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ign_ad31_o) |-> (sys_addr_o == $past(ad_i))); // R5

    AST_CLAIM_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(claim_o) |-> (sys_addr_o < $past(mem_limit_i))); // R6

    AST_RELEASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && frame_n_i && irdy_n_i)
        |=> (!claim_o && !ign_ad31_o && sys_addr_o == '0)); // R7

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && $past(state_q) == ST_HELD)
        |-> ($stable(claim_o) && $stable(ign_ad31_o) && $stable(sys_addr_o))); // R8
endmodule

bind isa_cycle_claim isa_cycle_claim_chk #(.AW(AW), .NUM_AGENTS(NUM_AGENTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gnt_n_i     (gnt_n_i),
    .frame_n_i   (frame_n_i),
    .irdy_n_i    (irdy_n_i),
    .cbe_n_i     (cbe_n_i),
    .ad_i        (ad_i),
    .self_init_i (self_init_i),
    .mem_limit_i (mem_limit_i),
    .ign_ad31_o  (ign_ad31_o),
    .claim_o     (claim_o),
    .sys_addr_o  (sys_addr_o),
    .state_q     (state_q)
);

// File: tb/test_isa_cycle_claim.sv
module test_isa_cycle_claim;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  gnt_n = 4'hF;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [3:0]  cbe_n = 4'h0;
    logic [31:0] ad = '0;
    logic        self_init = 1'b0;
    logic [31:0] mem_limit = '0;
    logic        ign_ad31, claim;
    logic [31:0] sys_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isa_cycle_claim i_isa_cycle_claim (
        .clk(clk), .rst_n(rst_n), .gnt_n_i(gnt_n), .frame_n_i(frame_n),
        .irdy_n_i(irdy_n), .cbe_n_i(cbe_n), .ad_i(ad), .self_init_i(self_init),
        .mem_limit_i(mem_limit), .ign_ad31_o(ign_ad31), .claim_o(claim),
        .sys_addr_o(sys_addr)
    );

    // Reference model of the claim decision, written from the requirements
    function automatic bit m_mem(input logic [3:0] c);
        return c == 4'b0110 || c == 4'b0111 || c == 4'b1100 || c == 4'b1110 || c == 4'b1111;
    endfunction
    function automatic logic [31:0] m_addr(input logic [3:0] g, input logic [31:0] a);
        return (&g) ? a : {~a[31], a[30:0]};
    endfunction
    function automatic bit m_claim(input logic [3:0] g, input logic [3:0] c,
                                   input logic [31:0] a, input bit s, input logic [31:0] l);
        bit hit;
        hit = (&g) ? 1'b1 : a[31];
        return !s && m_mem(c) && hit && (m_addr(g, a) < l);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input bit ec, input bit ef, input logic [31:0] ea);
        chk(claim == ec, {req, " claim"}, 32'(claim), 32'(ec));
        chk(ign_ad31 == ef, {req, " flag"}, 32'(ign_ad31), 32'(ef));
        chk(sys_addr == ea, {req, " addr"}, sys_addr, ea);
    endtask

    // One transaction: address clock, hold cycles with scrambled inputs, release
    task automatic run(input logic [3:0] g, input logic [3:0] c, input logic [31:0] a,
                       input bit s, input logic [31:0] l, input int hold, input string req);
        bit ec, ef;
        logic [31:0] ea;
        ec = m_claim(g, c, a, s, l);
        ef = &g;
        ea = m_addr(g, a);
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1;
        gnt_n = g; cbe_n = c; ad = a; self_init = s; mem_limit = l;
        @(negedge clk);
        check_out({req, " R9"}, ec, ef, ea);
        irdy_n = 1'b0;
        for (int i = 0; i < hold; i++) begin
            frame_n = (i == 0) ? 1'b0 : 1'b1;
            gnt_n = 4'($urandom); cbe_n = 4'($urandom); ad = $urandom;
            self_init = 1'($urandom); mem_limit = $urandom;
            @(negedge clk);
            check_out("R8 held", ec, ef, ea);
        end
        frame_n = 1'b1; irdy_n = 1'b1;
        @(negedge clk);
        check_out("R7 release", 1'b0, 1'b0, 32'h0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_out("R1 reset", 1'b0, 1'b0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 idle", 1'b0, 1'b0, 32'h0);

        // R2: one grant low clears the flag
        run(4'b1110, 4'b0110, 32'h0010_0000, 1'b0, 32'h0400_0000, 2, "R2 grant low");
        // R5: ISA cycle in low memory is claimed without inversion
        run(4'b1111, 4'b0111, 32'h0000_8000, 1'b0, 32'h0400_0000, 1, "R5 isa low");
        // R5: peer-to-peer style address with bit 31 set is still claimed
        run(4'b1111, 4'b0110, 32'h8000_1000, 1'b0, 32'hFFFF_FFFF, 1, "R5 isa high");
        // R5: limit boundary
        run(4'b1111, 4'b0110, 32'h0400_0000, 1'b0, 32'h0400_0000, 1, "R5 at limit");
        run(4'b1111, 4'b0110, 32'h03FF_FFFF, 1'b0, 32'h0400_0000, 1, "R5 below limit");
        // R6: ordinary cycles
        run(4'b0111, 4'b1100, 32'h8000_2000, 1'b0, 32'h0400_0000, 1, "R6 high half");
        run(4'b0111, 4'b1100, 32'h0000_2000, 1'b0, 32'h0400_0000, 1, "R6 low half");
        run(4'b1011, 4'b1110, 32'h8400_0000, 1'b0, 32'h0400_0000, 1, "R6 at limit");
        // R4: own cycle
        run(4'b1111, 4'b0110, 32'h0000_1000, 1'b1, 32'h0400_0000, 1, "R4 self");
        // R3: non-memory commands
        run(4'b1111, 4'b0010, 32'h0000_0100, 1'b0, 32'h0400_0000, 1, "R3 io read");
        run(4'b1111, 4'b1010, 32'h0000_0100, 1'b0, 32'h0400_0000, 1, "R3 config");
        run(4'b1111, 4'b0001, 32'h0000_0100, 1'b0, 32'h0400_0000, 1, "R3 special");

        // Mixed random transactions
        for (int k = 0; k < 400; k++) begin
            logic [3:0] g;
            logic [31:0] l;
            g = ($urandom % 2) ? 4'hF : 4'($urandom);
            l = ($urandom % 2) ? 32'($urandom % 32'h1000_0000) : $urandom;
            run(g, 4'($urandom), $urandom, ($urandom % 8) == 0, l,
                1 + int'($urandom % 4), "R2 R5 R6 random");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule